// File: doc/BRIEF.md
# Iterative Goldschmidt Fixed-Point Divider

This block divides one unsigned integer operand by another without ever forming a reciprocal and without a subtract-and-shift loop. Once an operation is accepted, the divisor is moved into the interval (0.5, 1] by a right shift of `s` places, chosen by a leading-one search. The dividend is shifted by the same amount, so the ratio of the two does not change. On each of `ITER` steps the block forms a correction factor equal to two minus the scaled divisor. It multiplies both scaled values by that factor in two independent multipliers that run side by side. The scaled divisor climbs toward one, and the error shrinks roughly as its square each step. The scaled dividend then approaches the true quotient.

A caller places the operands on the inputs and raises `start_i` for one cycle while the block is idle. It then waits for the one-cycle `done_o` pulse. The quotient is an unsigned fixed-point value with `W` integer bits and `F` fraction bits, so its real value is `quot_o / 2^F`. The normalizing shift is reported on `shift_o`, which lets a caller recover the scaled divisor as `den / 2^shift_o`. A zero divisor is refused at once with an error flag and no iteration takes place. Each product is cut back to `F` fraction bits by truncation toward zero. The parameter `F` must be at least `W` so that normalization drops no bits.

Top module: `gs_divider`

## Requirements
- R1: While `rst` is high and after it falls, `busy_o`, `done_o` and `err_o` are 0, and `quot_o` and `shift_o` read 0 until the first operation is accepted.
- R2: For an accepted nonzero divisor D, `shift_o` equals the smallest s with 2^s >= D, so D/2^s lies in (0.5, 1]. The scaled divisor stays in that interval on every iteration.
- R3: A start is accepted on a clock edge where `start_i` is 1 and `busy_o` is 0. For a nonzero divisor, `done_o` rises exactly ITER edges after the accepting edge and stays high for one cycle. `busy_o` stays high from the accepting edge until `done_o` falls.
- R4: For a nonzero divisor D that is not a power of two, let r = N/D. The quotient satisfies |quot_o/2^F − r| <= (1 + r)·16·2^-F + r·0.5^(2^ITER). The scaled divisor never decreases from one step to the next.
- R5: When D is a power of two 2^s, the quotient is exact: `quot_o` = N·2^(F−s).
- R6: A zero divisor gives `done_o` on the cycle right after the accepting edge, with `err_o` = 1 and `quot_o` = 0. The next accepted nonzero divisor clears `err_o`.
- R7: `start_i` and the operand inputs are ignored while `busy_o` is 1. The result belongs to the operands captured at the accepting edge.
- R8: After `done_o`, the outputs `quot_o`, `shift_o` and `err_o` hold their values while the block is idle, whatever the operand inputs do, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a division; taken only while idle |
| num_i | input | W | Unsigned dividend |
| den_i | input | W | Unsigned divisor |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| err_o | output | 1 | The last operation had a zero divisor |
| quot_o | output | W+F | Quotient, W integer bits and F fraction bits |
| shift_o | output | $clog2(W+1) | Normalizing shift applied to the divisor |

## Verification
The bench uses a reduced configuration (6-bit operands, 16 fraction bits, four steps) and runs every dividend against every divisor. Divisors that are powers of two start the divisor at exactly one, so an exact result shows that normalization and dividend scaling line up. Divisors just above a power of two start furthest from one and expose a missing or broken iteration through the error bound. A zero divisor checks the early-exit path. A start pulse sent while busy, and inputs that change during the idle time after completion, show that captured operands and held results are not disturbed.

// File: rtl/gs_div_pkg.sv
package gs_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } gs_state_e;

    // Width of a shift count able to represent 0..n
    function automatic int unsigned shift_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/gs_lod.sv
// Leading-one search with power-of-two detection; yields ceil(log2(val)).
module gs_lod #(
    parameter int W  = 8,
    parameter int SW = 4
) (
    input  logic [W-1:0]  val_i,
    output logic [SW-1:0] shift_o,
    output logic          zero_o
);
    logic [SW-1:0] hi_pos;
    logic          is_pow2;

    always_comb begin
        hi_pos = '0;
        for (int i = 0; i < W; i++) begin
            if (val_i[i]) hi_pos = SW'(i);
        end
    end

    assign zero_o  = (val_i == '0);
    assign is_pow2 = ((val_i & (val_i - 1'b1)) == '0);
    assign shift_o = (is_pow2 || zero_o) ? hi_pos : hi_pos + 1'b1;
endmodule

// File: rtl/gs_norm.sv
// Applies one common right shift to divisor and dividend, placing both
// in fixed point with F fraction bits.
module gs_norm #(
    parameter int W  = 8,
    parameter int F  = 18,
    parameter int SW = 4
) (
    input  logic [W-1:0]   num_i,
    input  logic [W-1:0]   den_i,
    input  logic [SW-1:0]  shift_i,
    output logic [F:0]     dsc_o,
    output logic [W+F-1:0] qsc_o
);
    localparam int XW = W + F;

    logic [XW-1:0] num_ext;
    logic [XW-1:0] den_ext;

    assign num_ext = {num_i, {F{1'b0}}};
    assign den_ext = {den_i, {F{1'b0}}};
    assign dsc_o   = (F+1)'(den_ext >> shift_i);
    assign qsc_o   = num_ext >> shift_i;
endmodule

// File: rtl/gs_step.sv
// One refinement step: factor = 2 - d, then two independent products,
// each truncated back to F fraction bits.
module gs_step #(
    parameter int W = 8,
    parameter int F = 18
) (
    input  logic [F:0]     dsc_i,
    input  logic [W+F-1:0] qsc_i,
    output logic [F:0]     dsc_o,
    output logic [W+F-1:0] qsc_o
);
    localparam int QW = W + F;
    localparam int DP = 2 * F + 2;
    localparam int QP = QW + F + 1;

    logic [F+1:0] two_fx;
    logic [F:0]   factor;
    logic [DP-1:0] d_prod;
    logic [QP-1:0] q_prod;

    assign two_fx = (F+2)'(1) << (F + 1);
    assign factor = (F+1)'(two_fx - {1'b0, dsc_i});

    assign d_prod = DP'(dsc_i) * DP'(factor);
    assign q_prod = QP'(qsc_i) * QP'(factor);

    assign dsc_o = (F+1)'(d_prod >> F);
    assign qsc_o = QW'(q_prod >> F);
endmodule

// File: rtl/gs_divider.sv
module gs_divider
    import gs_div_pkg::*;
#(
    parameter int W    = 8,
    parameter int F    = 18,
    parameter int ITER = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start_i,
    input  logic [W-1:0]                        num_i,
    input  logic [W-1:0]                        den_i,
    output logic                                busy_o,
    output logic                                done_o,
    output logic                                err_o,
    output logic [W+F-1:0]                      quot_o,
    output logic [shift_width(W)-1:0]           shift_o
);
    localparam int SW = shift_width(W);
    localparam int QW = W + F;
    localparam int CW = shift_width(ITER);

    gs_state_e     state;
    logic [F:0]    d_r;
    logic [QW-1:0] q_r;
    logic [CW-1:0] cnt;
    logic          err_r;
    logic [SW-1:0] shift_r;

    logic [SW-1:0] lod_shift;
    logic          lod_zero;
    logic [F:0]    d_init;
    logic [QW-1:0] q_init;
    logic [F:0]    d_next;
    logic [QW-1:0] q_next;
    logic          accept;

    gs_lod #(.W(W), .SW(SW)) u_lod (
        .val_i   (den_i),
        .shift_o (lod_shift),
        .zero_o  (lod_zero)
    );

    gs_norm #(.W(W), .F(F), .SW(SW)) u_norm (
        .num_i   (num_i),
        .den_i   (den_i),
        .shift_i (lod_shift),
        .dsc_o   (d_init),
        .qsc_o   (q_init)
    );

    gs_step #(.W(W), .F(F)) u_step (
        .dsc_i (d_r),
        .qsc_i (q_r),
        .dsc_o (d_next),
        .qsc_o (q_next)
    );

    assign accept = start_i && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            d_r     <= '0;
            q_r     <= '0;
            cnt     <= '0;
            err_r   <= 1'b0;
            shift_r <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        shift_r <= lod_shift;
                        err_r   <= lod_zero;
                        cnt     <= '0;
                        if (lod_zero) begin
                            d_r   <= '0;
                            q_r   <= '0;
                            state <= ST_FIN;
                        end else begin
                            d_r   <= d_init;
                            q_r   <= q_init;
                            state <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    d_r <= d_next;
                    q_r <= q_next;
                    if (cnt == CW'(ITER - 1)) begin
                        state <= ST_FIN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o  = (state != ST_IDLE);
    assign done_o  = (state == ST_FIN);
    assign err_o   = err_r;
    assign quot_o  = q_r;
    assign shift_o = shift_r;
endmodule

// File: rtl/gs_divider_chk.sv
module gs_divider_chk #(
    parameter int W    = 8,
    parameter int F    = 18,
    parameter int ITER = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           start_i,
    input logic [W-1:0]   den_i,
    input logic           busy_o,
    input logic           done_o,
    input logic           err_o,
    input logic [W+F-1:0] quot_o,
    input logic [F:0]     dsc,
    input logic           running
);
    localparam int LW = $clog2(ITER + 3) + 1;

    logic [LW-1:0] lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat <= '0;
        end else if (start_i && !busy_o) begin
            lat <= LW'(1);
        end else if (busy_o) begin
            lat <= lat + 1'b1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R3

    AST_RUN_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> (lat == LW'(ITER + 1))); // R3

    AST_ZERO_EXIT: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && den_i == '0) |=> (done_o && err_o && quot_o == '0)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !$past(busy_o)) |-> ($stable(quot_o) && $stable(err_o))); // R8

    AST_DIV_WINDOW: assert property (@(posedge clk) disable iff (rst)
        running |-> (dsc > (F+1)'(1) << (F - 1)) && (dsc <= (F+1)'(1) << F)); // R2

    AST_DIV_RISE: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |-> (dsc >= $past(dsc))); // R4
endmodule

bind gs_divider gs_divider_chk #(.W(W), .F(F), .ITER(ITER)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .den_i   (den_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .quot_o  (quot_o),
    .dsc     (d_r),
    .running (busy_o && !done_o)
);

// File: tb/tb_gs_divider.sv
module tb_gs_divider;
    localparam int  W       = 6;
    localparam int  F       = 16;
    localparam int  ITER    = 4;
    localparam int  QW      = W + F;
    localparam int  SW      = $clog2(W + 1);
    localparam time CLK_PER = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [W-1:0]  num_i = '0;
    logic [W-1:0]  den_i = '0;
    logic          busy_o;
    logic          done_o;
    logic          err_o;
    logic [QW-1:0] quot_o;
    logic [SW-1:0] shift_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int ticks = 0;

    gs_divider #(.W(W), .F(F), .ITER(ITER)) dut (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .num_i   (num_i),
        .den_i   (den_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .err_o   (err_o),
        .quot_o  (quot_o),
        .shift_o (shift_o)
    );

    always #(CLK_PER / 2) clk = ~clk;

    always @(posedge clk) begin
        ticks++;
        if (ticks > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", ticks);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // Issue one operation; leaves the bench at the negedge where done_o is seen.
    task automatic run_div(input int n, input int d);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        num_i   = W'(n);
        den_i   = W'(d);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic int ceil_log2(input int v);
        int s = 0;
        while ((1 << s) < v) s++;
        return s;
    endfunction

    task automatic check_result(input int n, input int d);
        real scale, r, qv, tol, conv, diff;
        int  s;
        longint exact;
        scale = 2.0 ** F;
        if (d == 0) begin
            chk(cyc == 1, "R6", $sformatf("zero latency actual=%0d expected=1", cyc));
            chk(err_o == 1'b1 && quot_o == '0, "R6",
                $sformatf("zero divisor err=%0b quot=%0d expected err=1 quot=0", err_o, quot_o));
            return;
        end
        s = ceil_log2(d);
        chk(cyc == ITER + 1, "R3", $sformatf("n=%0d d=%0d latency actual=%0d expected=%0d",
            n, d, cyc, ITER + 1));
        chk(err_o == 1'b0, "R6", $sformatf("n=%0d d=%0d err actual=%0b expected=0", n, d, err_o));
        chk(int'(shift_o) == s, "R2", $sformatf("d=%0d shift actual=%0d expected=%0d",
            d, shift_o, s));
        if ((d & (d - 1)) == 0) begin
            exact = (longint'(n) << F) >> s;
            chk(longint'(quot_o) == exact, "R5",
                $sformatf("n=%0d d=%0d quot actual=%0d expected=%0d", n, d, quot_o, exact));
        end else begin
            r    = real'(n) / real'(d);
            qv   = real'(quot_o) / scale;
            conv = 0.5;
            for (int k = 0; k < ITER; k++) conv = conv * conv;
            tol  = (1.0 + r) * 16.0 / scale + r * conv;
            diff = (qv > r) ? qv - r : r - qv;
            chk(diff <= tol, "R4", $sformatf("n=%0d d=%0d quot actual=%f expected=%f tol=%g",
                n, d, qv, r, tol));
        end
    endtask

    initial begin
        logic [QW-1:0] held_q;
        logic [SW-1:0] held_s;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !err_o && quot_o == '0 && shift_o == '0, "R1",
            $sformatf("in reset busy=%0b done=%0b err=%0b quot=%0d shift=%0d expected all 0",
            busy_o, done_o, err_o, quot_o, shift_o));
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o && !err_o && quot_o == '0, "R1",
            $sformatf("after reset busy=%0b done=%0b err=%0b quot=%0d expected all 0",
            busy_o, done_o, err_o, quot_o));

        // Exhaustive sweep: R2, R3, R4, R5, R6
        for (int n = 0; n < (1 << W); n++) begin
            for (int d = 0; d < (1 << W); d++) begin
                run_div(n, d);
                check_result(n, d);
            end
        end

        // R6: error cleared by the next nonzero divisor
        run_div(9, 0);
        chk(err_o == 1'b1, "R6", $sformatf("err after zero actual=%0b expected=1", err_o));
        run_div(9, 3);
        chk(err_o == 1'b0, "R6", $sformatf("err after 9/3 actual=%0b expected=0", err_o));

        // R7: start pulse while busy must not replace the operands
        @(negedge clk);
        while (busy_o) @(negedge clk);
        num_i = W'(50); den_i = W'(7); start_i = 1'b1;
        @(negedge clk);
        num_i = W'(1); den_i = W'(1);
        @(negedge clk);
        start_i = 1'b0;
        cyc = 2;
        while (!done_o && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == ITER + 1, "R7", $sformatf("latency with busy start actual=%0d expected=%0d",
            cyc, ITER + 1));
        check_result(50, 7);
        @(negedge clk);
        chk(!busy_o, "R7", $sformatf("busy after extra start actual=%0b expected=0", busy_o));

        // R8: outputs hold while idle with moving inputs
        run_div(45, 11);
        held_q = quot_o;
        held_s = shift_o;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            num_i = W'(k * 7 + 3);
            den_i = W'(k);
        end
        @(negedge clk);
        chk(quot_o == held_q && shift_o == held_s && !err_o && !done_o, "R8",
            $sformatf("idle hold quot actual=%0d expected=%0d shift actual=%0d expected=%0d",
            quot_o, held_q, shift_o, held_s));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule